// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits behind a serial memory's bus interface and gathers the data bytes of one write command into a small page buffer. The bus interface announces a new write command with a start strobe and the word address it received, then hands over each data byte with a one-cycle valid strobe. The low bits of an internal address pointer pick the buffer column for each byte and step after every byte. The upper bits name the page and never change during the command, so a long burst wraps around inside its own page. Bytes beyond the page size replace the earliest ones in arrival order.

Nothing reaches the memory array while bytes are being collected. When a Stop strobe ends a command that carried at least one byte, the block enters a self-timed write cycle. Busy stays high for a fixed number of clock cycles, set by a parameter. During the first cycles of that window the block walks the page columns in ascending order and pulses the array write port once for every column that received a byte. Columns that received nothing keep their old contents. The bus interface uses busy to withhold acknowledges, which lets a host poll for completion. An abort strobe, which the bus interface raises on a repeated Start, drops the collected bytes. A Stop with no bytes also drops the command without a write cycle.

The controller has four states. In IDLE it waits for a start strobe (IDLE to COLLECT). In COLLECT it stores bytes. From COLLECT, a start strobe reloads it (COLLECT to COLLECT). An abort, or a Stop with an empty buffer, returns it to IDLE (COLLECT to IDLE). A Stop with data begins the write cycle (COLLECT to COMMIT). COMMIT scans the columns and ends after the last one, going to HOLD, or straight to IDLE if the window is already used up. HOLD waits out the rest of the timed window (HOLD to IDLE).

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, busy is 0 and the array write enable is 0.
- R2: A byte accepted in COLLECT is stored in the buffer column given by the low 4 bits of the address pointer. Those bits then increment by one. The pointer is loaded from start_addr when a start strobe is accepted. A byte later lands in the array at address {upper 3 pointer bits, column}.
- R3: The column increment wraps from 15 to 0. The upper 3 address bits stay fixed, so a burst starting near the end of a page continues at column 0 of the same page.
- R4: When more than 16 bytes arrive in one command, each later byte overwrites the column it wraps onto. The array receives only the newest byte for each column.
- R5: The array write enable stays 0 while bytes are collected. It rises only after a Stop has ended the command.
- R6: A Stop that ends a command holding at least one byte raises busy on the next clock cycle. Busy then stays high for exactly WRITE_CYCLES consecutive cycles.
- R7: Inside the busy window the array is written once per received column, one column per cycle, in ascending column order starting at column 0. Columns that received no byte are not written.
- R8: An abort, or a Stop with no byte received, ends the command without asserting busy and without any array write.
- R9: While busy is high, start, byte, Stop and abort strobes are ignored.
- R10: An accepted start strobe clears every buffered byte and column flag, including when it arrives in COLLECT. Only bytes received after it are written.
- R11: Byte and Stop strobes in IDLE have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | One-cycle strobe: a new write command begins |
| start_addr | input | 7 | Word address of the first byte, sampled with cmd_start |
| byte_valid | input | 1 | One-cycle strobe: byte_data holds a received data byte |
| byte_data | input | 8 | Received data byte |
| stop_strobe | input | 1 | One-cycle strobe: a Stop condition ended the command |
| abort_strobe | input | 1 | One-cycle strobe: the command was abandoned (repeated Start) |
| arr_we | output | 1 | Array write enable, one cycle per written byte |
| arr_addr | output | 7 | Array write address |
| arr_wdata | output | 8 | Array write data |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
The assertions assume that the bus interface raises at most one of its strobes in a given cycle. They also assume that WRITE_CYCLES is at least the page size, so that the column scan fits inside the busy window. The stimulus keeps to both assumptions. Every strobe is a separate one-cycle pulse with at least one quiet cycle after it, and the bench sets a 40-cycle write window against the 16-byte page. The bench also drives strobes while busy is high and while the controller is idle, to show that those strobes are ignored.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_COMMIT  = 2'd2,
        ST_HOLD    = 2'd3
    } pgc_state_e;

endpackage

// File: rtl/pgc_col_ptr.sv
module pgc_col_ptr #(
    parameter int ADDR_W = 7,
    parameter int COL_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [ADDR_W-1:0]       load_addr,
    input  logic                    step,
    output logic [ADDR_W-COL_W-1:0] page,
    output logic [COL_W-1:0]        col
);

    localparam int PAGE_W = ADDR_W - COL_W;

    logic [PAGE_W-1:0] page_q;
    logic [COL_W-1:0]  col_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            col_q  <= '0;
        end else if (load) begin
            page_q <= load_addr[ADDR_W-1:COL_W];
            col_q  <= load_addr[COL_W-1:0];
        end else if (step) begin
            col_q  <= col_q + 1'b1;
        end
    end

    assign page = page_q;
    assign col  = col_q;

    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (col == COL_W'($past(col) + 1'b1))); // R2

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(page)); // R3

endmodule

// File: rtl/pgc_page_buf.sv
module pgc_page_buf #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int COL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0]  vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_col == COL_W'(i)) begin
                    mem_q[i] <= wr_data;
                    vld_q[i] <= 1'b1;
                end
            end
        end
    end

    assign rd_data   = mem_q[rd_col];
    assign rd_valid  = vld_q[rd_col];
    assign any_valid = |vld_q;

    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !any_valid); // R10

    AST_WR_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |=> any_valid); // R2

endmodule

// File: rtl/pgc_commit_timer.sv
module pgc_commit_timer #(
    parameter int WRITE_CYCLES = 50000,
    parameter int CNT_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    output logic [CNT_W-1:0] count,
    output logic             last
);

    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(WRITE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (run && cnt_q != LAST_VAL) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;
    assign last  = (cnt_q == LAST_VAL);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_VAL); // R6

    AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && !last) |=> (count == CNT_W'($past(count) + 1'b1))); // R6

endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl #(
    parameter int ADDR_W       = 7,
    parameter int DATA_W       = 8,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_strobe,
    input  logic              abort_strobe,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              busy
);

    import pgc_pkg::*;

    localparam int COL_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - COL_W;
    localparam int TCW    = $clog2(WRITE_CYCLES + 1);
    localparam logic [TCW-1:0] SCAN_LAST = TCW'(PAGE_BYTES - 1);

    pgc_state_e state_q, state_d;

    logic [PAGE_W-1:0] page;
    logic [COL_W-1:0]  col;
    logic [COL_W-1:0]  scan_col;
    logic [TCW-1:0]    tmr_count;
    logic              tmr_last;
    logic              tmr_clear;
    logic              accept_start;
    logic              buf_wr;
    logic              any_valid;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              in_busy;

    // strobes are honoured only outside the timed window
    assign accept_start = cmd_start && (state_q == ST_IDLE || state_q == ST_COLLECT);
    assign buf_wr       = byte_valid && (state_q == ST_COLLECT)
                          && !cmd_start && !abort_strobe && !stop_strobe;
    assign in_busy      = (state_q == ST_COMMIT) || (state_q == ST_HOLD);
    assign tmr_clear    = (state_q != ST_COMMIT) && (state_q != ST_HOLD);
    assign scan_col     = tmr_count[COL_W-1:0];

    pgc_col_ptr #(
        .ADDR_W (ADDR_W),
        .COL_W  (COL_W)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept_start),
        .load_addr (start_addr),
        .step      (buf_wr),
        .page      (page),
        .col       (col)
    );

    pgc_page_buf #(
        .DATA_W (DATA_W),
        .DEPTH  (PAGE_BYTES),
        .COL_W  (COL_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept_start),
        .wr_en     (buf_wr),
        .wr_col    (col),
        .wr_data   (byte_data),
        .rd_col    (scan_col),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .any_valid (any_valid)
    );

    pgc_commit_timer #(
        .WRITE_CYCLES (WRITE_CYCLES),
        .CNT_W        (TCW)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .run   (in_busy),
        .count (tmr_count),
        .last  (tmr_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_start) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (cmd_start)         state_d = ST_COLLECT;
                else if (abort_strobe) state_d = ST_IDLE;
                else if (stop_strobe)  state_d = any_valid ? ST_COMMIT : ST_IDLE;
            end
            ST_COMMIT: begin
                if (tmr_count == SCAN_LAST) state_d = tmr_last ? ST_IDLE : ST_HOLD;
            end
            ST_HOLD: begin
                if (tmr_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        arr_we    = 1'b0;
        arr_addr  = {page, scan_col};
        arr_wdata = rd_data;
        unique case (state_q)
            ST_IDLE:    ;
            ST_COLLECT: ;
            ST_COMMIT: begin
                busy   = 1'b1;
                arr_we = rd_valid;
            end
            ST_HOLD: begin
                busy   = 1'b1;
            end
            default: ;
        endcase
    end

    AST_WE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy); // R5

    AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_strobe)); // R6

    AST_BUSY_ENDS_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tmr_last)); // R6

    AST_EMPTY_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT && stop_strobe && !cmd_start && !abort_strobe && !any_valid)
        |=> !busy); // R8

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT && abort_strobe && !cmd_start) |=> (!busy && !arr_we)); // R8

    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!buf_wr && !accept_start)); // R9

    AST_PAGE_DURING_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(busy)) |-> $stable(arr_addr[ADDR_W-1:COL_W])); // R3

endmodule

// File: tb/page_commit_ctrl_test.sv
module page_commit_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 7;
    localparam int DW = 8;
    localparam int PB = 16;
    localparam int WC = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          byte_valid = 1'b0;
    logic [DW-1:0] byte_data = '0;
    logic          stop_strobe = 1'b0;
    logic          abort_strobe = 1'b0;
    logic          arr_we;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_wdata;
    logic          busy;

    page_commit_ctrl #(
        .ADDR_W       (AW),
        .DATA_W       (DW),
        .PAGE_BYTES   (PB),
        .WRITE_CYCLES (WC)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_start    (cmd_start),
        .start_addr   (start_addr),
        .byte_valid   (byte_valid),
        .byte_data    (byte_data),
        .stop_strobe  (stop_strobe),
        .abort_strobe (abort_strobe),
        .arr_we       (arr_we),
        .arr_addr     (arr_addr),
        .arr_wdata    (arr_wdata),
        .busy         (busy)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [AW+DW-1:0] expq[$];

    // reference model: 0 idle, 1 collecting, 2 write window
    int            m_state = 0;
    logic [DW-1:0] m_data [PB];
    logic [PB-1:0] m_vld = '0;
    logic [AW-1:0] m_ptr = '0;
    int            busy_run = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // monitor: pops expected writes, measures busy windows
    always @(negedge clk) begin
        if (rst_n) begin
            if (arr_we) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R5/R9 stray array write", {arr_addr, arr_wdata}, 0);
                end else begin
                    logic [AW+DW-1:0] item;
                    item = expq.pop_front();
                    chk({arr_addr, arr_wdata} == item, "R7 array write", {arr_addr, arr_wdata}, item);
                end
            end
            if (busy) begin
                busy_run++;
            end else if (busy_run != 0) begin
                chk(busy_run == WC, "R6 busy length", busy_run, WC);
                busy_run = 0;
            end
        end
    end

    task automatic start_cmd(input logic [AW-1:0] a);
        @(negedge clk);
        cmd_start  = 1'b1;
        start_addr = a;
        if (m_state != 2) begin
            m_state = 1;
            m_vld   = '0;
            m_ptr   = a;
        end
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic send_byte(input logic [DW-1:0] d);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = d;
        if (m_state == 1) begin
            m_data[m_ptr[3:0]] = d;
            m_vld[m_ptr[3:0]]  = 1'b1;
            m_ptr = {m_ptr[AW-1:4], 4'(m_ptr[3:0] + 4'd1)};
        end
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic send_stop();
        bit was_collect;
        bit exp_busy;
        @(negedge clk);
        stop_strobe = 1'b1;
        was_collect = (m_state == 1);
        exp_busy    = 1'b0;
        if (was_collect) begin
            if (m_vld != '0) begin
                for (int i = 0; i < PB; i++) begin
                    if (m_vld[i]) expq.push_back({m_ptr[AW-1:4], 4'(i), m_data[i]});
                end
                m_state  = 2;
                exp_busy = 1'b1;
            end else begin
                m_state = 0;
            end
        end
        @(negedge clk);
        stop_strobe = 1'b0;
        if (was_collect) chk(busy == exp_busy, exp_busy ? "R6 busy after stop" : "R8 empty stop", busy, exp_busy);
    endtask

    task automatic send_abort();
        @(negedge clk);
        abort_strobe = 1'b1;
        if (m_state == 1) m_state = 0;
        @(negedge clk);
        abort_strobe = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 4 * WC) begin
            @(negedge clk);
            guard++;
        end
        if (m_state == 2) m_state = 0;
        @(negedge clk);
        chk(expq.size() == 0, "R7 all expected writes seen", expq.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(arr_we == 1'b0, "R1 write enable after reset", arr_we, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 single byte
        start_cmd(7'h25);
        send_byte(8'hA5);
        send_stop();
        wait_idle();

        // R2 R7 short page burst from column 0
        start_cmd(7'h30);
        for (int i = 0; i < 4; i++) send_byte(8'h10 + 8'(i));
        send_stop();
        wait_idle();

        // R3 wrap within page
        start_cmd(7'h4E);
        send_byte(8'hC1);
        send_byte(8'hC2);
        send_byte(8'hC3);
        send_stop();
        wait_idle();

        // R4 overflow: 18 bytes from column 0
        start_cmd(7'h10);
        for (int i = 0; i < 18; i++) send_byte(8'(i + 1));
        @(negedge clk);
        chk(busy == 1'b0, "R5 no busy while collecting", busy, 0);
        chk(arr_we == 1'b0, "R5 no write while collecting", arr_we, 0);
        send_stop();
        wait_idle();

        // R8 empty stop and abort
        start_cmd(7'h22);
        send_stop();
        start_cmd(7'h23);
        send_byte(8'h77);
        send_byte(8'h78);
        send_abort();
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R8 abort leaves idle", busy, 0);

        // R10 restart clears earlier bytes
        start_cmd(7'h60);
        send_byte(8'h91);
        send_byte(8'h92);
        send_byte(8'h93);
        start_cmd(7'h65);
        send_byte(8'h5E);
        send_stop();
        wait_idle();

        // R9 strobes during the write window
        start_cmd(7'h08);
        send_byte(8'hE0);
        send_stop();
        start_cmd(7'h70);
        send_byte(8'hEE);
        send_stop();
        send_abort();
        wait_idle();
        repeat (WC + 5) @(negedge clk);
        chk(busy == 1'b0, "R9 ignored strobes start nothing", busy, 0);

        // R11 strobes while idle
        send_byte(8'h3C);
        send_stop();
        repeat (WC + 5) @(negedge clk);
        chk(busy == 1'b0, "R11 idle strobes ignored", busy, 0);
        chk(expq.size() == 0, "R11 no writes from idle strobes", expq.size(), 0);

        finish_run();
    end

endmodule